// File: doc/BRIEF.md
# Low-Power Mode Controller

This block moves the chip between four power modes on software request and turns the mode into clock and power controls. In Normal the CPU and peripherals run from the PLL. In Slow they run from the slow reference clock with the PLL bypassed. In Idle only the CPU clock stops. In Sleep both clock domains are gated and the core power is then switched off. The controller itself runs on the always-on reference clock.

Software writes the requested mode through a one-cycle write strobe. An already-masked interrupt request from the interrupt controller brings the chip out of Idle. Only the sixteen external interrupt lines or the RTC alarm can bring it out of Sleep. After such a wake, power returns at once, but the clocks stay off for a programmable settle time before the block returns to Normal. A return from Slow to Normal keeps the slow clock selected until the PLL reports lock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is active and after it is released, the block is in Normal: `cur_mode`=0, `cpu_clk_en`=1, `per_clk_en`=1, `clk_src_pll`=1 and `core_pwr_off`=0.
- R2: Modes are encoded on `cur_mode` and `mode_wdata` as Normal=0, Slow=1, Idle=2 and Sleep=3. In Normal, a write (`mode_wr`=1) is sampled on a clock edge, and the new mode appears on `cur_mode` directly after that edge. A write of 0 in Normal leaves the block in Normal.
- R3: In Slow, `clk_src_pll`=0 and both clock enables are 1. A write of 1, 2 or 3 while in Slow is ignored and the block stays in Slow.
- R4: A write of 0 in Slow keeps `cur_mode`=1 and `clk_src_pll`=0 until `pll_locked` is sampled high. After that edge, `cur_mode`=0 and `clk_src_pll`=1.
- R5: In Idle, `cpu_clk_en`=0, `per_clk_en`=1 and `clk_src_pll`=1. When `irq_req` is sampled high, the block is in Normal with `cpu_clk_en`=1 directly after that edge.
- R6: In Idle, mode writes are ignored. If a write and `irq_req` arrive in the same cycle, the block goes to Normal and the write has no effect.
- R7: After a write of 3 in Normal, the next cycle shows `cur_mode`=3 with both clock enables 0 and `core_pwr_off`=0. `core_pwr_off` rises one cycle later.
- R8: While powered off in Sleep, the block leaves Sleep only when some bit of `ext_irq` or `rtc_alarm` is sampled high. `irq_req` and `mode_wr` have no effect there.
- R9: On the wake edge, `settle_cycles`=N is captured. From that edge on, `core_pwr_off`=0 and `cur_mode`=3, and both clock enables stay 0 for N+1 cycles. The block then enters Normal with both clocks enabled.
- R10: Outside Sleep, `ext_irq` and `rtc_alarm` have no effect on the mode or on any output.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Requested mode |
| irq_req | input | 1 | Masked interrupt request (Idle wake) |
| ext_irq | input | 16 | External interrupt lines (Sleep wake) |
| rtc_alarm | input | 1 | RTC alarm (Sleep wake) |
| pll_locked | input | 1 | PLL lock indication |
| settle_cycles | input | SETTLE_W | Clock settle count after wake |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| clk_src_pll | output | 1 | 1 selects PLL clock, 0 the slow reference |
| core_pwr_off | output | 1 | Core power-off request |
| cur_mode | output | 2 | Current mode |

## Verification
Two events can land in the same cycle: a mode write that arrives while Idle is being left on an interrupt, and, in Sleep, a plain interrupt request together with or ahead of a true wake source. The bench drives a Sleep write and `irq_req` together while in Idle and expects Normal with the CPU clock back on the next cycle. It also holds `irq_req` and a write high while powered off and expects the power-off request to persist until an external line rises. It then counts the gated cycles that follow the wake.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr,
  input  logic [1:0]          mode_wdata,
  input  logic                irq_req,
  input  logic [15:0]         ext_irq,
  input  logic                rtc_alarm,
  input  logic                pll_locked,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                cpu_clk_en,
  output logic                per_clk_en,
  output logic                clk_src_pll,
  output logic                core_pwr_off,
  output logic [1:0]          cur_mode
);

  localparam logic [1:0] M_NORMAL = 2'd0;
  localparam logic [1:0] M_SLOW   = 2'd1;
  localparam logic [1:0] M_IDLE   = 2'd2;
  localparam logic [1:0] M_SLEEP  = 2'd3;

  typedef enum logic [2:0] {
    S_NORMAL, S_SLOW, S_RELOCK, S_IDLE, S_GATE, S_OFF, S_SETTLE
  } state_t;

  state_t              st, st_nxt;
  logic [SETTLE_W-1:0] cnt;
  logic                wake;

  assign wake = (|ext_irq) | rtc_alarm;

  always_comb begin
    st_nxt = st;
    case (st)
      S_NORMAL: if (mode_wr)
                  case (mode_wdata)
                    M_SLOW:  st_nxt = S_SLOW;
                    M_IDLE:  st_nxt = S_IDLE;
                    M_SLEEP: st_nxt = S_GATE;
                    default: st_nxt = S_NORMAL;
                  endcase
      S_SLOW:   if (mode_wr && mode_wdata == M_NORMAL) st_nxt = S_RELOCK;
      S_RELOCK: if (pll_locked) st_nxt = S_NORMAL;
      S_IDLE:   if (irq_req) st_nxt = S_NORMAL;
      S_GATE:   st_nxt = S_OFF;
      S_OFF:    if (wake) st_nxt = S_SETTLE;
      S_SETTLE: if (cnt == '0) st_nxt = S_NORMAL;
      default:  st_nxt = S_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_NORMAL;
      cnt <= '0;
    end else begin
      st <= st_nxt;
      if (st == S_OFF && wake) cnt <= settle_cycles;
      else if (st == S_SETTLE && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign cpu_clk_en   = (st == S_NORMAL) || (st == S_SLOW) || (st == S_RELOCK);
  assign per_clk_en   = cpu_clk_en || (st == S_IDLE);
  assign clk_src_pll  = !((st == S_SLOW) || (st == S_RELOCK));
  assign core_pwr_off = (st == S_OFF);

  always_comb begin
    case (st)
      S_SLOW, S_RELOCK:      cur_mode = M_SLOW;
      S_IDLE:                cur_mode = M_IDLE;
      S_GATE, S_OFF, S_SETTLE: cur_mode = M_SLEEP;
      default:               cur_mode = M_NORMAL;
    endcase
  end

  // clocks are already gated the cycle before power goes off
  assert_gate_before_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr_off) |-> ($past(!cpu_clk_en) && $past(!per_clk_en)));

  assert_idle_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_IDLE && irq_req) |=> (cpu_clk_en && cur_mode == M_NORMAL));

  assert_pll_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_src_pll) |-> $past(pll_locked));

  assert_wake_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr_off) |-> $past(wake));

  assert_power_on_no_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr_off) |-> (!cpu_clk_en && !per_clk_en && cur_mode == M_SLEEP));

endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SW = 8;

  logic clk = 0, rst_n = 0;
  logic mode_wr = 0, irq_req = 0, rtc_alarm = 0, pll_locked = 0;
  logic [1:0] mode_wdata = 0;
  logic [15:0] ext_irq = 0;
  logic [SW-1:0] settle_cycles = 0;
  logic cpu_clk_en, per_clk_en, clk_src_pll, core_pwr_off;
  logic [1:0] cur_mode;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.SETTLE_W(SW)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .irq_req(irq_req), .ext_irq(ext_irq), .rtc_alarm(rtc_alarm),
    .pll_locked(pll_locked), .settle_cycles(settle_cycles),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .clk_src_pll(clk_src_pll),
    .core_pwr_off(core_pwr_off), .cur_mode(cur_mode));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // outputs packed {mode[1:0], cpu, per, src, off}
  function automatic int outs();
    return {cur_mode, cpu_clk_en, per_clk_en, clk_src_pll, core_pwr_off};
  endfunction
  function automatic int pk(input int m, input int c, input int p, input int s, input int o);
    return (m << 4) | (c << 3) | (p << 2) | (s << 1) | o;
  endfunction

  task automatic step(); @(negedge clk); endtask
  task automatic write_mode(input int m);
    mode_wr = 1; mode_wdata = 2'(m); step(); mode_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 in reset", outs(), pk(0,1,1,1,0));
    rst_n = 1; step(); step();
    chk("R1 after reset", outs(), pk(0,1,1,1,0));
    write_mode(0);
    chk("R2 write Normal in Normal", outs(), pk(0,1,1,1,0));
  endtask

  task automatic t_outside_wake();
    ext_irq = 16'h8001; rtc_alarm = 1; step();
    chk("R10 wake lines in Normal", outs(), pk(0,1,1,1,0));
    ext_irq = 0; rtc_alarm = 0;
  endtask

  task automatic t_slow();
    write_mode(1);
    chk("R2/R3 enter Slow", outs(), pk(1,1,1,0,0));
    write_mode(2);
    chk("R3 Idle write ignored in Slow", outs(), pk(1,1,1,0,0));
    write_mode(3);
    chk("R3 Sleep write ignored in Slow", outs(), pk(1,1,1,0,0));
    ext_irq = 16'h0010; step(); ext_irq = 0;
    chk("R10 wake line in Slow", outs(), pk(1,1,1,0,0));
    write_mode(0);
    chk("R4 waiting for lock", outs(), pk(1,1,1,0,0));
    step(); step();
    chk("R4 still waiting", outs(), pk(1,1,1,0,0));
    pll_locked = 1; step(); pll_locked = 0;
    chk("R4 Normal after lock", outs(), pk(0,1,1,1,0));
  endtask

  task automatic t_idle();
    write_mode(2);
    chk("R2/R5 enter Idle", outs(), pk(2,0,1,1,0));
    rtc_alarm = 1; step(); rtc_alarm = 0;
    chk("R10 alarm in Idle", outs(), pk(2,0,1,1,0));
    write_mode(1);
    chk("R6 write ignored in Idle", outs(), pk(2,0,1,1,0));
    irq_req = 1; step(); irq_req = 0;
    chk("R5 irq wakes Idle", outs(), pk(0,1,1,1,0));
    write_mode(2);
    irq_req = 1; mode_wr = 1; mode_wdata = 3; step();
    irq_req = 0; mode_wr = 0;
    chk("R6 irq beats write in Idle", outs(), pk(0,1,1,1,0));
    step();
    chk("R6 write dropped", outs(), pk(0,1,1,1,0));
  endtask

  task automatic t_sleep(input int n, input bit use_rtc);
    settle_cycles = SW'(n);
    write_mode(3);
    chk("R7 clocks gated first", outs(), pk(3,0,0,1,0));
    step();
    chk("R7 power off one cycle later", outs(), pk(3,0,0,1,1));
    irq_req = 1; mode_wr = 1; mode_wdata = 0; step(); step();
    chk("R8 irq and write ignored in Sleep", outs(), pk(3,0,0,1,1));
    irq_req = 0; mode_wr = 0;
    if (use_rtc) rtc_alarm = 1; else ext_irq = 16'h0400;
    step();
    rtc_alarm = 0; ext_irq = 0; settle_cycles = SW'(n + 5);
    for (int k = 0; k <= n; k++) begin
      chk("R9 powered, clocks held off", outs(), pk(3,0,0,1,0));
      if (k < n) step();
    end
    step();
    chk("R9 Normal after settle", outs(), pk(0,1,1,1,0));
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    t_outside_wake();
    t_slow();
    t_idle();
    t_sleep(3, 0);
    t_sleep(0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule